// File: doc/BRIEF.md
# DMA Transfer Address and Count Engine

This block is the datapath of one DMA channel. Software programs a 16-bit base address, a 16-bit count, an 8-bit page value and two mode bits (byte or word addressing, and automatic reload). The engine then runs the transfer one cycle at a time. When a request arrives and the channel is unmasked, it presents a 24-bit physical address and waits for the bus to acknowledge it. On each acknowledge the address steps up by one and the count steps down by one.

The count register holds one less than the number of transfers. The last transfer is therefore the one acknowledged while the count reads zero. At that point the engine raises terminal count for one cycle. Without automatic reload it also masks the channel and leaves the count at 0xFFFF, which is a residue of zero. With automatic reload it restores the current address and count from their base copies and stays unmasked. The address register never carries into the page. A transfer therefore wraps inside a 64 KB page in byte mode and inside a 128 KB page in word mode.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is held, and after it is released, xfer_req and tc are 0, masked is 1, and cur_addr and cur_cnt are 0x0000.
- R2: A pulse on cfg_we while no transfer is pending copies cfg_addr and cfg_cnt into both the base and the current registers, and latches cfg_page, cfg_word and cfg_auto. A cfg_we pulse while xfer_req is 1 is ignored.
- R3: xfer_req rises one cycle after a cycle in which dreq is 1, masked is 0 and no transfer is pending. It never rises while masked is 1.
- R4: In byte mode (cfg_word=0), phys_addr equals {page[7:0], cur_addr[15:0]}.
- R5: In word mode (cfg_word=1), phys_addr equals {page[7:1], cur_addr[15:0], 1'b0}. Page bit 0 has no effect.
- R6: Each acknowledged transfer adds one to cur_addr modulo 2^16. The page is never changed, so 0xFFFF wraps to 0x0000.
- R7: Each acknowledged transfer subtracts one from cur_cnt. A programmed count of N yields exactly N+1 transfers.
- R8: tc is 1 for exactly the one cycle after the acknowledge given while cur_cnt is 0x0000, and is 0 at all other times.
- R9: Without automatic reload, the terminal acknowledge sets masked and leaves cur_cnt at 0xFFFF. mask_set sets masked, and mask_clr clears it unless a set happens in the same cycle.
- R10: With automatic reload (cfg_auto=1), the terminal acknowledge restores cur_addr and cur_cnt from the base values and leaves masked at 0.
- R11: While xfer_req is 1 and bus_ack is 0, xfer_req stays 1 and phys_addr stays constant on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_addr | input | 16 | Base address value |
| cfg_cnt | input | 16 | Base count value (transfers minus one) |
| cfg_page | input | 8 | Page value |
| cfg_word | input | 1 | 1 selects word addressing, 0 selects byte addressing |
| cfg_auto | input | 1 | 1 enables reload after terminal count |
| mask_set | input | 1 | Sets the channel mask |
| mask_clr | input | 1 | Clears the channel mask |
| dreq | input | 1 | Transfer request from the device |
| bus_ack | input | 1 | Acknowledge of the pending transfer |
| xfer_req | output | 1 | A transfer is pending at phys_addr |
| phys_addr | output | 24 | Physical address of the pending transfer |
| tc | output | 1 | Terminal count pulse |
| masked | output | 1 | Channel mask state |
| cur_addr | output | 16 | Current address register |
| cur_cnt | output | 16 | Current count register (residue minus one) |

## Verification
A request is registered, so xfer_req and its address are checked on the falling edge after the first rising edge that sees dreq with the channel unmasked. An acknowledge takes effect at the next rising edge. cur_addr, cur_cnt, masked and tc are therefore all sampled on the falling edge that follows the acknowledging edge, where the tc pulse is visible for that one cycle only. Configuration loads take one edge and are read back on the next falling edge. After reset release the bench waits out the two-stage reset synchronizer before the first check. Every stimulus is driven on a falling edge, so inputs never change near the edges that sample them.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma_addr_ctr.sv
// Current-address register: loads, steps by one with natural wrap, or reloads.
module dma_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              reload,
  input  logic [ADDR_W-1:0] reload_val,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load | step;
    addr_d  = addr_q;
    if (load)                 addr_d = load_val;
    else if (step && reload)  addr_d = reload_val;
    else if (step)            addr_d = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_cnt_ctr.sv
// Current-count register holding transfers-minus-one.
module dma_cnt_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | step;
    cnt_d  = cnt_q;
    if (load)                cnt_d = load_val;
    else if (step && reload) cnt_d = reload_val;
    else if (step)           cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/dma_phys_map.sv
// Forms the physical address from page and address for byte or word mode.
module dma_phys_map #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] addr,
  input  logic              word_mode,
  output logic [PHYS_W-1:0] phys
);
  logic [PHYS_W-1:0] byte_form, word_form;

  assign byte_form = {page, addr};
  assign word_form = {page[PAGE_W-1:1], addr, 1'b0};

  always_comb begin
    phys = word_mode ? word_form : byte_form;
  end
endmodule

// File: rtl/dma_xfer_seq.sv
// Transfer sequencer: start condition, acknowledge handling, mask and terminal count.
module dma_xfer_seq
  import dma_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic bus_ack,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic cnt_zero,
  input  logic autoinit,
  output logic busy,
  output logic step,
  output logic last,
  output logic tc,
  output logic masked
);
  seq_state_e state_q, state_d;
  logic       mask_q, mask_d;
  logic       tc_q, tc_d;
  logic       start;

  always_comb begin
    busy  = (state_q == SEQ_BUSY);
    start = (state_q == SEQ_IDLE) && dreq && !mask_q;
    step  = busy && bus_ack;
    last  = step && cnt_zero;

    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_BUSY;
      SEQ_BUSY: if (bus_ack) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase

    mask_d = mask_q;
    if ((last && !autoinit) || mask_set) mask_d = 1'b1;
    else if (mask_clr)                   mask_d = 1'b0;

    tc_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mask_q  <= 1'b1;
      tc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      tc_q    <= tc_d;
    end
  end

  assign tc     = tc_q;
  assign masked = mask_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_word,
  input  logic              cfg_auto,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              dreq,
  input  logic              bus_ack,
  output logic              xfer_req,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              tc,
  output logic              masked,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt
);
  logic              rst_n_i;
  logic              busy, step, last, cnt_zero, load;
  logic [ADDR_W-1:0] base_addr_q;
  logic [CNT_W-1:0]  base_cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic              word_q, auto_q;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign load = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      word_q      <= 1'b0;
      auto_q      <= 1'b0;
    end else if (load) begin
      base_addr_q <= cfg_addr;
      base_cnt_q  <= cfg_cnt;
      page_q      <= cfg_page;
      word_q      <= cfg_word;
      auto_q      <= cfg_auto;
    end
  end

  dma_xfer_seq u_seq (
    .clk(clk), .rst_n(rst_n_i), .dreq(dreq), .bus_ack(bus_ack),
    .mask_set(mask_set), .mask_clr(mask_clr), .cnt_zero(cnt_zero),
    .autoinit(auto_q), .busy(busy), .step(step), .last(last),
    .tc(tc), .masked(masked)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n_i), .load(load), .load_val(cfg_addr),
    .step(step), .reload(last && auto_q), .reload_val(base_addr_q),
    .addr(cur_addr)
  );

  dma_cnt_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .load(load), .load_val(cfg_cnt),
    .step(step), .reload(last && auto_q), .reload_val(base_cnt_q),
    .cnt(cur_cnt), .is_zero(cnt_zero)
  );

  dma_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
    .page(page_q), .addr(cur_addr), .word_mode(word_q), .phys(phys_addr)
  );

  assign xfer_req = busy;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PHYS_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_req,
  input logic              bus_ack,
  input logic              tc,
  input logic              masked,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [ADDR_W-1:0] base_addr,
  input logic [CNT_W-1:0]  base_cnt,
  input logic              auto_q
);
  a_r3_no_start_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_req && masked) |=> !xfer_req);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && bus_ack && cur_cnt != '0) |=> cur_addr == $past(cur_addr) + 1'b1);

  a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && bus_ack && cur_cnt != '0) |=> cur_cnt == $past(cur_cnt) - 1'b1);

  a_r8_tc_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && bus_ack && cur_cnt == '0) |=> tc);

  a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  a_r9_mask_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_q) |-> (masked && cur_cnt == '1));

  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && bus_ack && cur_cnt == '0 && auto_q) |=>
      (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr) && !masked));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !bus_ack) |=> (xfer_req && $stable(phys_addr)));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .bus_ack(bus_ack),
  .tc(tc), .masked(masked), .phys_addr(phys_addr), .cur_addr(cur_addr),
  .cur_cnt(cur_cnt), .base_addr(base_addr_q), .base_cnt(base_cnt_q),
  .auto_q(auto_q)
);

// File: tb/dma_xfer_engine_tb.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_word, cfg_auto, mask_set, mask_clr, dreq, bus_ack;
  logic [15:0] cfg_addr, cfg_cnt;
  logic [7:0]  cfg_page;
  logic        xfer_req, tc, masked;
  logic [23:0] phys_addr;
  logic [15:0] cur_addr, cur_cnt;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  dma_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_cnt(cfg_cnt), .cfg_page(cfg_page), .cfg_word(cfg_word),
    .cfg_auto(cfg_auto), .mask_set(mask_set), .mask_clr(mask_clr),
    .dreq(dreq), .bus_ack(bus_ack), .xfer_req(xfer_req),
    .phys_addr(phys_addr), .tc(tc), .masked(masked),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic load_cfg(input logic [7:0] pg, input logic [15:0] a,
                          input logic [15:0] c, input logic w, input logic au);
    cfg_we = 1'b1; cfg_page = pg; cfg_addr = a; cfg_cnt = c;
    cfg_word = w; cfg_auto = au;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic unmask();
    mask_clr = 1'b1;
    @(negedge clk);
    mask_clr = 1'b0;
  endtask

  // One transfer: request, check address, optional wait, acknowledge, check tc.
  task automatic do_xfer(input string req, input logic [23:0] exp_addr,
                         input logic exp_tc, input int hold);
    int n = 0;
    dreq = 1'b1;
    @(negedge clk);
    while (!xfer_req && n < 20) begin @(negedge clk); n++; end
    dreq = 1'b0;
    chk({req, " xfer_req"}, {31'd0, xfer_req}, 32'd1);
    chk({req, " phys_addr"}, {8'd0, phys_addr}, {8'd0, exp_addr});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 hold req", {31'd0, xfer_req}, 32'd1);
      chk("R11 hold addr", {8'd0, phys_addr}, {8'd0, exp_addr});
    end
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R8 tc", {31'd0, tc}, {31'd0, exp_tc});
    @(negedge clk);
    chk("R8 tc one cycle", {31'd0, tc}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 xfer_req", {31'd0, xfer_req}, 32'd0);
    chk("R1 tc", {31'd0, tc}, 32'd0);
    chk("R1 masked", {31'd0, masked}, 32'd1);
    chk("R1 cur_addr", {16'd0, cur_addr}, 32'd0);
    chk("R1 cur_cnt", {16'd0, cur_cnt}, 32'd0);
  endtask

  task automatic t_byte_mode();
    load_cfg(8'h12, 16'h3456, 16'h0002, 1'b0, 1'b0);
    chk("R2 load addr", {16'd0, cur_addr}, 32'h3456);
    chk("R2 load cnt", {16'd0, cur_cnt}, 32'h0002);
    dreq = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 masked blocks start", {31'd0, xfer_req}, 32'd0);
    dreq = 1'b0;
    unmask();
    do_xfer("R4 byte 0", 24'h123456, 1'b0, 0);
    chk("R7 cnt after one", {16'd0, cur_cnt}, 32'h0001);
    do_xfer("R4 byte 1", 24'h123457, 1'b0, 0);
    do_xfer("R7 byte last", 24'h123458, 1'b1, 0);
    chk("R9 masked after tc", {31'd0, masked}, 32'd1);
    chk("R9 residue", {16'd0, cur_cnt}, 32'hFFFF);
    chk("R6 addr after run", {16'd0, cur_addr}, 32'h3459);
    dreq = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 no fourth transfer", {31'd0, xfer_req}, 32'd0);
    dreq = 1'b0;
  endtask

  task automatic t_word_mode();
    load_cfg(8'h35, 16'h1000, 16'h0001, 1'b1, 1'b0);
    unmask();
    do_xfer("R5 word 0", 24'h342000, 1'b0, 0);
    do_xfer("R5 word 1", 24'h342002, 1'b1, 0);
    chk("R9 masked word", {31'd0, masked}, 32'd1);
  endtask

  task automatic t_wrap();
    load_cfg(8'h07, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
    unmask();
    do_xfer("R6 wrap pre", 24'h07FFFF, 1'b0, 0);
    chk("R6 wrapped addr", {16'd0, cur_addr}, 32'h0000);
    do_xfer("R6 wrap stays in page", 24'h070000, 1'b1, 0);
  endtask

  task automatic t_autoinit();
    load_cfg(8'h01, 16'h0010, 16'h0001, 1'b0, 1'b1);
    unmask();
    do_xfer("R10 auto 0", 24'h010010, 1'b0, 2);
    do_xfer("R10 auto 1", 24'h010011, 1'b1, 0);
    chk("R10 masked clear", {31'd0, masked}, 32'd0);
    chk("R10 addr reload", {16'd0, cur_addr}, 32'h0010);
    chk("R10 cnt reload", {16'd0, cur_cnt}, 32'h0001);
    do_xfer("R10 after reload", 24'h010010, 1'b0, 0);
    mask_set = 1'b1;
    @(negedge clk);
    mask_set = 1'b0;
    chk("R9 mask_set", {31'd0, masked}, 32'd1);
  endtask

  task automatic t_load_busy();
    int n = 0;
    load_cfg(8'h20, 16'h0100, 16'h0000, 1'b0, 1'b0);
    unmask();
    dreq = 1'b1;
    @(negedge clk);
    while (!xfer_req && n < 20) begin @(negedge clk); n++; end
    dreq = 1'b0;
    load_cfg(8'h44, 16'hABCD, 16'h0055, 1'b1, 1'b1);
    chk("R2 load ignored addr", {16'd0, cur_addr}, 32'h0100);
    chk("R2 load ignored phys", {8'd0, phys_addr}, 32'h200100);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R8 tc single", {31'd0, tc}, 32'd1);
    chk("R9 residue busy case", {16'd0, cur_cnt}, 32'hFFFF);
    chk("R9 masked busy case", {31'd0, masked}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = 1'b0; cfg_auto = 1'b0;
    mask_set = 1'b0; mask_clr = 1'b0; dreq = 1'b0; bus_ack = 1'b0;
    cfg_addr = '0; cfg_cnt = '0; cfg_page = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte_mode();
    t_word_mode();
    t_wrap();
    t_autoinit();
    t_load_busy();
    finish_run();
  end
endmodule